// File: doc/BRIEF.md
# Counter-Mode Block Cipher Sequencer with Host Register Front End

This block is the control side of a memory-to-memory block-encryption engine. A host reaches its byte-wide registers through a small command bus. The registers are:

- a base memory address
- a job length in bytes
- a 128-bit counter
- two 128-bit keys
- a one-bit key selector

Writing the value 1 to the launch register while the engine is idle starts a job. The job walks external byte-wide memory in 16-byte blocks and works in place.

For each block the sequencer does three things in order:

1. It reads the sixteen bytes one per cycle and packs them into a 128-bit block.
2. It hands the block, the counter and the selected key to an external cipher core through a request/done handshake.
3. It writes the sixteen result bytes back to the addresses they came from.

The block's byte offset then advances by 16. The job ends when that advance would not stay below the length, so a length of 0 still processes one block. While a job runs, the host can still read every register, including the current phase. Register writes are dropped until the engine is idle again.

Top module: `ctr_crypt_ctrl`

## Requirements
- R1: The command input is 2 bits wide. Value 1 is a register read, value 2 is a register write, and values 0 and 3 change no register and no read data.
- R2: The register window is 0xFF00..0xFF3F. The address map is:
  - 0xFF02/03: base address, low byte first
  - 0xFF04/05: length, low byte first
  - 0xFF06: key select, bit 0
  - 0xFF10+k: byte k of the counter, covering bits [8k+7:8k]
  - 0xFF20+k: byte k of key 0
  - 0xFF30+k: byte k of key 1
  
  Read data appears on `host_rdata` in the cycle after the read command and holds until the next read.
- R3: A read of 0xFF00, of an unmapped offset inside the window (0xFF07..0xFF0F), or of any address outside the window returns 0x00.
- R4: Register writes take effect only while the phase is idle. A write in any other phase changes nothing.
- R5: Writing data 1 to 0xFF00 while idle moves the phase to READ and clears the byte offset to 0. Any other data value written there starts nothing.
- R6: In READ the engine issues one memory read per cycle, for address base + offset + k with k = 0..15, using 16-bit wraparound. Each read returns its byte one cycle later, and that byte goes to block bits [8k+7:8k]. A read and a write are never issued in the same cycle.
- R7: In OPERATE, `cph_req` stays high until `cph_done` is seen. `cph_ctr` carries the counter, `cph_blk` carries the block, and `cph_key` carries key 0 when key select is 0 and key 1 otherwise. The result is captured in the cycle `cph_done` is high.
- R8: In WRITE the engine writes result bits [8k+7:8k] to base + offset + k for k = 0..15. If offset + 16 < length, the offset grows by 16 and the phase returns to READ; otherwise the phase returns to idle.
- R9: Address 0xFF01 reads the phase, zero-extended to 8 bits: 0 is idle, 1 is READ, 2 is OPERATE and 3 is WRITE. The phase can be read at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cmd | input | 2 | Host command: 1 read, 2 write, other values no-op |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| mem_addr | output | 16 | External memory byte address |
| mem_rd_en | output | 1 | Memory read strobe, data expected on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| cph_req | output | 1 | Cipher request, held until done |
| cph_ctr | output | 128 | Counter value sent to the cipher |
| cph_key | output | 128 | Selected key sent to the cipher |
| cph_blk | output | 128 | Plaintext block sent to the cipher |
| cph_done | input | 1 | Cipher completion strobe |
| cph_result | input | 128 | Cipher output block |

## Verification
The in-line properties watch the following on every cycle:
- busy-time writes leave the register set untouched;
- out-of-window reads return zero;
- a launch lands in READ with a zero offset;
- OPERATE holds until done;
- the offset moves only by a block step or to zero;
- memory is never read and written in the same cycle.

Some behaviour only the bench scenarios can show. Correct byte ordering, the choice of key, the block count for lengths of 0, 16, 17, 40 and 48, and address carry across a 256-byte boundary all appear only in the final memory image. The bench compares that image with a model it computes itself. Its exhaustive sweep of the register window covers the address map.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_OPER  = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_e;

  localparam logic [1:0] CMD_READ  = 2'd1;
  localparam logic [1:0] CMD_WRITE = 2'd2;
endpackage

// File: rtl/ccc_regs.sv
module ccc_regs
  import ccc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          BLK_BYTES = 16,
  parameter logic [15:0] WIN_BASE  = 16'hFF00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             host_cmd,
  input  logic [AW-1:0]          host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic [1:0]             seq_state,
  output logic                   start_o,
  output logic [AW-1:0]          base_o,
  output logic [AW-1:0]          len_o,
  output logic                   ksel_o,
  output logic [BLK_BYTES*8-1:0] ctr_o,
  output logic [BLK_BYTES*8-1:0] key0_o,
  output logic [BLK_BYTES*8-1:0] key1_o
);
  localparam int BW     = $clog2(BLK_BYTES);
  localparam int OFF_W  = BW + 2;
  localparam int N_WIDE = 3;

  logic          in_win, is_rd, is_wr, idle, wr_ok;
  logic [1:0]    grp;
  logic [BW-1:0] bidx;
  logic [1:0]    ctl_idx;
  logic          ctl_hit;
  logic [7:0]    rd_d;

  logic [7:0] ctl_q [4];
  logic       ksel_q;
  logic [7:0] wide_q [N_WIDE][BLK_BYTES];

  assign in_win  = host_addr[AW-1:OFF_W] == WIN_BASE[AW-1:OFF_W];
  assign grp     = host_addr[OFF_W-1:BW];
  assign bidx    = host_addr[BW-1:0];
  assign is_rd   = host_cmd == CMD_READ;
  assign is_wr   = host_cmd == CMD_WRITE;
  assign idle    = seq_state == ST_IDLE;
  assign wr_ok   = is_wr && idle && in_win;
  assign ctl_idx = bidx[1:0] - 2'd2;
  assign ctl_hit = (grp == 2'd0) && (bidx >= BW'(2)) && (bidx <= BW'(5));
  assign start_o = wr_ok && (grp == 2'd0) && (bidx == '0) && (host_wdata == 8'd1);

  // control bytes: base lo/hi, length lo/hi
  for (genvar c = 0; c < 4; c++) begin : g_ctl
    logic we;
    assign we = wr_ok && ctl_hit && (ctl_idx == 2'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q[c] <= '0;
      else if (we) ctl_q[c] <= host_wdata;
    end
  end

  logic ksel_we;
  assign ksel_we = wr_ok && (grp == 2'd0) && (bidx == BW'(6));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ksel_q <= 1'b0;
    else if (ksel_we) ksel_q <= host_wdata[0];
  end

  // counter, key 0, key 1 byte banks
  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
      logic we;
      assign we = wr_ok && (grp == 2'(g + 1)) && (bidx == BW'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  wide_q[g][b] <= '0;
        else if (we) wide_q[g][b] <= host_wdata;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BLK_BYTES; b++) begin
      ctr_o[8*b +: 8]  = wide_q[0][b];
      key0_o[8*b +: 8] = wide_q[1][b];
      key1_o[8*b +: 8] = wide_q[2][b];
    end
  end

  assign base_o = {ctl_q[1], ctl_q[0]};
  assign len_o  = {ctl_q[3], ctl_q[2]};
  assign ksel_o = ksel_q;

  // read mux
  always_comb begin
    rd_d = '0;
    if (in_win) begin
      case (grp)
        2'd0: begin
          if (bidx == BW'(1))      rd_d = {6'b0, seq_state};
          else if (ctl_hit)        rd_d = ctl_q[ctl_idx];
          else if (bidx == BW'(6)) rd_d = {7'b0, ksel_q};
          else                     rd_d = '0;
        end
        2'd1:    rd_d = wide_q[0][bidx];
        2'd2:    rd_d = wide_q[1][bidx];
        default: rd_d = wide_q[2][bidx];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     host_rdata <= '0;
    else if (is_rd) host_rdata <= rd_d;
  end

  AST_WR_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !idle) |=> ($stable(base_o) && $stable(len_o) && $stable(ksel_o) &&
                          $stable(ctr_o) && $stable(key0_o) && $stable(key1_o))) // R4
    else $error("write accepted while busy");

  AST_RD_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !in_win) |=> (host_rdata == 8'h00)) // R3
    else $error("out-of-window read not zero");

  AST_PHASE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && in_win && grp == 2'd0 && bidx == BW'(1)) |=> (host_rdata[7:2] == 6'b0)) // R9
    else $error("phase read not zero-extended");
endmodule

// File: rtl/ccc_seq.sv
module ccc_seq
  import ccc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [AW-1:0]          base_i,
  input  logic [AW-1:0]          len_i,
  input  logic                   ksel_i,
  input  logic [BLK_BYTES*8-1:0] ctr_i,
  input  logic [BLK_BYTES*8-1:0] key0_i,
  input  logic [BLK_BYTES*8-1:0] key1_i,
  output logic [1:0]             state_o,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_rd_en,
  input  logic [7:0]             mem_rdata,
  output logic                   mem_wr_en,
  output logic [7:0]             mem_wdata,
  output logic                   cph_req,
  output logic [BLK_BYTES*8-1:0] cph_ctr,
  output logic [BLK_BYTES*8-1:0] cph_key,
  output logic [BLK_BYTES*8-1:0] cph_blk,
  input  logic                   cph_done,
  input  logic [BLK_BYTES*8-1:0] cph_result
);
  localparam int BW = $clog2(BLK_BYTES);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [BW:0]   beat_q, beat_d;
  logic [BW-1:0] cap_idx_q, cap_idx_d;
  logic          rd_pend_q, rd_pend_d;
  logic          more_blk;

  logic [7:0]           buf_q [BLK_BYTES];
  logic [7:0]           buf_d [BLK_BYTES];
  logic [BLK_BYTES-1:0] buf_en;

  assign more_blk = ({1'b0, cnt_q} + (AW+1)'(BLK_BYTES)) < {1'b0, len_i};
  assign mem_addr = base_i + cnt_q + AW'(beat_q);
  assign state_o  = st_q;
  assign cph_ctr  = ctr_i;
  assign cph_key  = ksel_i ? key1_i : key0_i;

  // next state
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    beat_d    = beat_q;
    cap_idx_d = cap_idx_q;
    rd_pend_d = 1'b0;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_wdata = '0;
    cph_req   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_READ;
          cnt_d  = '0;
          beat_d = '0;
        end
      end
      ST_READ: begin
        if (beat_q < (BW+1)'(BLK_BYTES)) begin
          mem_rd_en = 1'b1;
          rd_pend_d = 1'b1;
          cap_idx_d = beat_q[BW-1:0];
          beat_d    = beat_q + 1'b1;
        end
        if (rd_pend_q && cap_idx_q == BW'(BLK_BYTES - 1)) begin
          st_d   = ST_OPER;
          beat_d = '0;
        end
      end
      ST_OPER: begin
        cph_req = 1'b1;
        if (cph_done) begin
          st_d   = ST_WRITE;
          beat_d = '0;
        end
      end
      default: begin
        mem_wr_en = 1'b1;
        mem_wdata = buf_q[beat_q[BW-1:0]];
        beat_d    = beat_q + 1'b1;
        if (beat_q == (BW+1)'(BLK_BYTES - 1)) begin
          beat_d = '0;
          if (more_blk) begin
            cnt_d = cnt_q + AW'(BLK_BYTES);
            st_d  = ST_READ;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_comb begin
    for (int b = 0; b < BLK_BYTES; b++) begin
      buf_en[b] = (rd_pend_q && cap_idx_q == BW'(b)) || (st_q == ST_OPER && cph_done);
      buf_d[b]  = (st_q == ST_OPER) ? cph_result[8*b +: 8] : mem_rdata;
      cph_blk[8*b +: 8] = buf_q[b];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      beat_q    <= '0;
      cap_idx_q <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      beat_q    <= beat_d;
      cap_idx_q <= cap_idx_d;
      rd_pend_q <= rd_pend_d;
    end
  end

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         buf_q[b] <= '0;
      else if (buf_en[b]) buf_q[b] <= buf_d[b];
    end
  end

  AST_START_ENTERS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_READ && cnt_q == '0)) // R5
    else $error("launch did not enter READ");

  AST_MEM_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)) // R6
    else $error("memory read and write together");

  AST_OPER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPER && !cph_done) |=> (st_q == ST_OPER && cph_req)) // R7
    else $error("left OPERATE without done");

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + AW'(BLK_BYTES) || cnt_q == '0)) // R8
    else $error("offset moved by an illegal step");

  AST_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRITE && beat_q == (BW+1)'(BLK_BYTES - 1) && more_blk)
      |=> (st_q == ST_READ && cnt_q == $past(cnt_q) + AW'(BLK_BYTES))) // R8
    else $error("block advance wrong");
endmodule

// File: rtl/ctr_crypt_ctrl.sv
module ctr_crypt_ctrl
  import ccc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          BLK_BYTES = 16,
  parameter logic [15:0] WIN_BASE  = 16'hFF00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             host_cmd,
  input  logic [AW-1:0]          host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_rd_en,
  input  logic [7:0]             mem_rdata,
  output logic                   mem_wr_en,
  output logic [7:0]             mem_wdata,
  output logic                   cph_req,
  output logic [BLK_BYTES*8-1:0] cph_ctr,
  output logic [BLK_BYTES*8-1:0] cph_key,
  output logic [BLK_BYTES*8-1:0] cph_blk,
  input  logic                   cph_done,
  input  logic [BLK_BYTES*8-1:0] cph_result
);
  localparam int BLK_W = BLK_BYTES * 8;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic             start;
  logic [1:0]       seq_state;
  logic [AW-1:0]    base, len;
  logic             ksel;
  logic [BLK_W-1:0] ctr, key0, key1;

  ccc_regs #(.AW(AW), .BLK_BYTES(BLK_BYTES), .WIN_BASE(WIN_BASE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .host_cmd   (host_cmd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .seq_state  (seq_state),
    .start_o    (start),
    .base_o     (base),
    .len_o      (len),
    .ksel_o     (ksel),
    .ctr_o      (ctr),
    .key0_o     (key0),
    .key1_o     (key1)
  );

  ccc_seq #(.AW(AW), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start),
    .base_i     (base),
    .len_i      (len),
    .ksel_i     (ksel),
    .ctr_i      (ctr),
    .key0_i     (key0),
    .key1_i     (key1),
    .state_o    (seq_state),
    .mem_addr   (mem_addr),
    .mem_rd_en  (mem_rd_en),
    .mem_rdata  (mem_rdata),
    .mem_wr_en  (mem_wr_en),
    .mem_wdata  (mem_wdata),
    .cph_req    (cph_req),
    .cph_ctr    (cph_ctr),
    .cph_key    (cph_key),
    .cph_blk    (cph_blk),
    .cph_done   (cph_done),
    .cph_result (cph_result)
  );
endmodule

// File: tb/ctr_crypt_ctrl_bench.sv
`timescale 1ns/1ps
module ctr_crypt_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   host_cmd = 2'd0;
  logic [15:0]  host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic [15:0]  mem_addr;
  logic         mem_rd_en, mem_wr_en;
  logic [7:0]   mem_rdata, mem_wdata;
  logic         cph_req;
  logic [127:0] cph_ctr, cph_key, cph_blk, cph_result;
  logic         cph_done;
  logic [1:0]   wait_cnt;
  logic         mem_load = 1'b0;

  logic [7:0] mem_m [256];
  logic [7:0] exp_m [256];

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ctr_crypt_ctrl u_ctr_crypt_ctrl (
    .clk(clk), .rst_n(rst_n), .host_cmd(host_cmd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .cph_req(cph_req), .cph_ctr(cph_ctr),
    .cph_key(cph_key), .cph_blk(cph_blk), .cph_done(cph_done),
    .cph_result(cph_result)
  );

  function automatic logic [7:0] fill_pat(input int i);
    return 8'(i * 29 + 7);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_load) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= fill_pat(i);
    end else begin
      if (mem_wr_en) mem_m[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem_m[mem_addr[7:0]];
    end
  end

  // stand-in cipher: XOR of its inputs, done three cycles after request
  assign cph_result = cph_blk ^ cph_key ^ cph_ctr;
  always @(posedge clk) begin
    if (!cph_req) begin
      wait_cnt <= 2'd0;
      cph_done <= 1'b0;
    end else if (cph_done) begin
      cph_done <= 1'b0;
    end else begin
      wait_cnt <= wait_cnt + 2'd1;
      if (wait_cnt == 2'd2) cph_done <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_cmd_raw(input logic [1:0] c, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cmd = c; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cmd = 2'd0;
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    host_cmd_raw(2'd2, a, d);
  endtask

  task automatic host_read(input logic [15:0] a, output logic [7:0] d);
    host_cmd_raw(2'd1, a, 8'h00);
    d = host_rdata;
  endtask

  task automatic set_wide(input logic [15:0] base_a, input logic [127:0] v);
    for (int k = 0; k < 16; k++) host_write(base_a + 16'(k), v[8*k +: 8]);
  endtask

  function automatic logic [7:0] reg_pat(input int off);
    return 8'(off * 37 + 11);
  endfunction

  function automatic logic [7:0] reg_exp(input int off);
    if (off == 0 || off == 1) return 8'h00;
    if (off >= 2 && off <= 5) return reg_pat(off);
    if (off == 6) return reg_pat(off) & 8'h01;
    if (off < 16) return 8'h00;
    return reg_pat(off);
  endfunction

  task automatic run_job(input logic [15:0] base, input logic [15:0] len, input bit ks,
                         input logic [127:0] c, input logic [127:0] k0, input logic [127:0] k1,
                         input string tag);
    logic [7:0]   d;
    logic [127:0] key;
    int           cnt, mism, first;
    bit           more;
    host_write(16'hFF02, base[7:0]);
    host_write(16'hFF03, base[15:8]);
    host_write(16'hFF04, len[7:0]);
    host_write(16'hFF05, len[15:8]);
    host_write(16'hFF06, {7'b0, ks});
    set_wide(16'hFF10, c);
    set_wide(16'hFF20, k0);
    set_wide(16'hFF30, k1);
    // model
    key = ks ? k1 : k0;
    cnt = 0;
    do begin
      for (int k = 0; k < 16; k++) begin
        int a;
        a = (int'(base) + cnt + k) & 255;
        exp_m[a] = exp_m[a] ^ key[8*k +: 8] ^ c[8*k +: 8];
      end
      more = (cnt + 16) < int'(len);
      cnt += 16;
    end while (more);
    host_read(16'hFF1F, d);
    check(d == c[127:120], {"R2 counter top byte ", tag}, d, c[127:120]);
    host_write(16'hFF00, 8'h01);
    host_read(16'hFF01, d);
    check(d == 8'h01, {"R5 R9 phase READ after launch ", tag}, d, 8'h01);
    host_write(16'hFF20, ~k0[7:0]);
    host_write(16'hFF02, ~base[7:0]);
    for (int i = 0; i < 3000; i++) begin
      host_read(16'hFF01, d);
      if (d == 8'h00) break;
    end
    check(d == 8'h00, {"R8 idle after job ", tag}, d, 8'h00);
    mism = 0; first = 0;
    for (int i = 0; i < 256; i++) begin
      if (mem_m[i] !== exp_m[i]) begin
        if (mism == 0) first = i;
        mism++;
      end
    end
    check(mism == 0, {"R6 R7 R8 memory image ", tag}, mem_m[first], exp_m[first]);
    host_read(16'hFF20, d);
    check(d == k0[7:0], {"R4 busy write to key 0 ignored ", tag}, d, k0[7:0]);
    host_read(16'hFF02, d);
    check(d == base[7:0], {"R4 busy write to base ignored ", tag}, d, base[7:0]);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 256; i++) exp_m[i] = fill_pat(i);
    mem_load = 1'b1;
    repeat (3) @(posedge clk);
    #1 mem_load = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(host_rdata == 8'h00, "R2 rdata after reset", host_rdata, 8'h00);
    host_read(16'hFF01, d);
    check(d == 8'h00, "R9 phase idle after reset", d, 8'h00);
    host_read(16'hFF3F, d);
    check(d == 8'h00, "R2 key 1 cleared by reset", d, 8'h00);

    // full window sweep
    for (int off = 0; off < 64; off++) host_write(16'hFF00 + 16'(off), reg_pat(off));
    host_read(16'hFF01, d);
    check(d == 8'h00, "R5 launch byte other than 1 starts nothing", d, 8'h00);
    for (int off = 0; off < 64; off++) begin
      host_read(16'hFF00 + 16'(off), d);
      check(d == reg_exp(off), $sformatf("R2 R3 window offset %0d", off), d, reg_exp(off));
    end

    // no-op commands
    host_cmd_raw(2'd3, 16'hFF10, 8'h5A);
    host_cmd_raw(2'd0, 16'hFF11, 8'h5A);
    host_read(16'hFF10, d);
    check(d == reg_pat(16), "R1 command 3 leaves counter byte", d, reg_pat(16));
    host_read(16'hFF11, d);
    check(d == reg_pat(17), "R1 command 0 leaves counter byte", d, reg_pat(17));
    host_cmd_raw(2'd0, 16'hFF12, 8'h00);
    check(host_rdata == reg_pat(17), "R1 no-op keeps read data", host_rdata, reg_pat(17));

    // outside window
    host_read(16'h1234, d);
    check(d == 8'h00, "R3 read outside window", d, 8'h00);
    host_write(16'h1210, 8'h77);
    host_read(16'hFF10, d);
    check(d == reg_pat(16), "R3 write outside window ignored", d, reg_pat(16));

    // jobs
    run_job(16'h0020, 16'd16, 1'b0, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
            128'h00112233445566778899aabbccddeeff, 128'hfedcba98765432100123456789abcdef, "one block key0");
    run_job(16'h10F0, 16'd40, 1'b1, 128'h11111111222222223333333344444444,
            128'h0badf00d0badf00d0badf00d0badf00d, 128'hc001d00dc001d00dc001d00d12345678, "three blocks key1 carry");
    run_job(16'h0080, 16'd0, 1'b1, 128'h0123456789abcdef0123456789abcdef,
            128'h5555aaaa5555aaaa5555aaaa5555aaaa, 128'h9999666699996666999966669999ffff, "length zero");
    run_job(16'h0040, 16'd48, 1'b0, 128'hdeadbeefdeadbeefdeadbeefdeadbeef,
            128'h13579bdf2468ace013579bdf2468ace0, 128'h0, "length exact multiple");
    run_job(16'h00C0, 16'd17, 1'b0, 128'h8080808080808080808080808080807f,
            128'h0102030405060708090a0b0c0d0e0f10, 128'h1, "length 17 two blocks");

    finish_run();
  end
endmodule